// File: doc/BRIEF.md
# Parallel RGB LCD Timing Generator

This block produces the raster timing for a 24-bit parallel RGB panel from a single pixel clock. It runs a pixel counter and a line counter and decodes them into an active-low horizontal sync, an active-low vertical sync, a data-enable strobe and 24 bits of colour. Each blanking interval is counted from the falling edge of its sync pulse, so the sync pulse lies inside the blanking interval. The visible window opens a fixed number of counts after that edge. While the window is open the block drives one constant fill colour, red by default. Outside the window it drives zero.

The default geometry is an 800x480 visible area. A line is 1056 clocks: 46 blanking, 800 visible and a 210-clock front porch. A frame is 525 lines: 23 blanking, 480 visible and a 22-line front porch. This gives about 60 frames per second from a 32 MHz pixel clock, or about 30 from 16 MHz; the logic does not depend on the clock rate. The raw pixel and line counts are exported alongside the sync signals so that downstream logic can generate its own pixel data. Every output is registered from the same count pair, so all outputs change on the same clock edge.

Top module: `rgb_panel_timer`

## Requirements
- R1: A synchronous active-high reset clears both counters to 0. While reset is applied, the outputs hold their idle values: hsync_n=1, vsync_n=1, de=0, rgb=0, px=0, ln=0.
- R2: The pixel count steps by one on every clock from 0 to H_TOTAL-1, then returns to 0. H_TOTAL = H_BLANK+H_ACTIVE+H_FRONT, which is 1056 by default.
- R3: The line count changes only when the pixel count wraps. It then steps by one, and it returns to 0 after V_TOTAL-1. V_TOTAL is 525 by default.
- R4: hsync_n is low exactly when the pixel count is below H_SYNC_W, so it falls at pixel count 0. H_SYNC_W defaults to 1 and must lie in 1..H_BLANK.
- R5: vsync_n is low exactly when the line count is below V_SYNC_W, so it falls at line count 0. V_SYNC_W defaults to 1 and must lie in 1..V_BLANK.
- R6: The horizontal window is open for pixel counts from H_BLANK up to H_BLANK+H_ACTIVE-1. With the defaults that is 46 to 845.
- R7: The vertical window is open for line counts from V_BLANK up to V_BLANK+V_ACTIVE-1. With the defaults that is 23 to 502.
- R8: de is high exactly when both windows are open.
- R9: rgb equals FILL while de is high and 0 otherwise. rgb[23:16] is red, rgb[15:8] is green and rgb[7:0] is blue. FILL defaults to 24'hFF0000 (solid red).
- R10: All outputs are registered from one count pair, with one clock of latency. After the first rising edge that samples reset low, px and ln read 0 and 0, and both syncs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, high for visible pixels |
| rgb | output | 24 | Pixel colour: red 23:16, green 15:8, blue 7:0 |
| px | output | HW | Pixel count within the line, HW = clog2(H_TOTAL) |
| ln | output | VW | Line count within the frame, VW = clog2(V_TOTAL) |

## Verification
Each output is due one clock after the count pair that produced it. The first rising edge that samples reset low therefore presents count pair (0,0), and the edge k clocks later presents count index k. The bench keeps a single index n of the edges since reset was released. From n and the parameters alone it derives the expected pixel count, line count, syncs, window and colour. It samples at the falling edge after each rising edge. The same index is restarted after a reset applied in mid-frame, to show that the count realigns to the first edge.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

    localparam int unsigned RGB_W = 24;

    typedef logic [RGB_W-1:0] rgb_t;

    // Decoded state of one raster axis
    typedef struct packed {
        logic sync_n;
        logic active;
    } axis_flags_t;

    // Registered panel pins
    typedef struct packed {
        logic hsync_n;
        logic vsync_n;
        logic de;
        rgb_t rgb;
    } pins_t;

    localparam pins_t PINS_IDLE = '{hsync_n: 1'b1, vsync_n: 1'b1, de: 1'b0, rgb: '0};

endpackage

// File: rtl/lcd_axis_counter.sv
module lcd_axis_counter #(
    parameter int unsigned TOTAL = 1056,
    parameter int unsigned W     = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] count,
    output logic         wrap
);

    localparam logic [W-1:0] LAST = W'(TOTAL - 1);
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (adv) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
    assign wrap  = adv && (cnt_q == LAST);

endmodule

// File: rtl/lcd_axis_decode.sv
module lcd_axis_decode #(
    parameter int unsigned BLANK  = 46,
    parameter int unsigned ACTIVE = 800,
    parameter int unsigned SYNC_W = 1,
    parameter int unsigned W      = 11
) (
    input  logic [W-1:0]             count,
    output lcd_tim_pkg::axis_flags_t flags
);

    // Compare one bit wider than the count so a window reaching TOTAL still fits
    localparam logic [W:0] SYNC_END = (W+1)'(SYNC_W);
    localparam logic [W:0] WIN_OPEN = (W+1)'(BLANK);
    localparam logic [W:0] WIN_SHUT = (W+1)'(BLANK + ACTIVE);

    generate
        if (SYNC_W < 1 || SYNC_W > BLANK) begin : g_bad_sync
            $error("sync width must lie between 1 and the blanking length");
        end
    endgenerate

    logic [W:0] cnt_x;

    always_comb begin
        cnt_x        = {1'b0, count};
        flags.sync_n = !(cnt_x < SYNC_END);
        flags.active = (cnt_x >= WIN_OPEN) && (cnt_x < WIN_SHUT);
    end

endmodule

// File: rtl/rgb_panel_timer.sv
module rgb_panel_timer #(
    parameter int unsigned       H_ACTIVE = 800,
    parameter int unsigned       H_BLANK  = 46,
    parameter int unsigned       H_FRONT  = 210,
    parameter int unsigned       V_ACTIVE = 480,
    parameter int unsigned       V_BLANK  = 23,
    parameter int unsigned       V_FRONT  = 22,
    parameter int unsigned       H_SYNC_W = 1,
    parameter int unsigned       V_SYNC_W = 1,
    parameter logic [23:0]       FILL     = 24'hFF0000,
    localparam int unsigned      H_TOTAL  = H_BLANK + H_ACTIVE + H_FRONT,
    localparam int unsigned      V_TOTAL  = V_BLANK + V_ACTIVE + V_FRONT,
    localparam int unsigned      HW       = $clog2(H_TOTAL),
    localparam int unsigned      VW       = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          de,
    output logic [23:0]   rgb,
    output logic [HW-1:0] px,
    output logic [VW-1:0] ln
);

    import lcd_tim_pkg::*;

    typedef struct packed {
        pins_t         pins;
        logic [HW-1:0] px;
        logic [VW-1:0] ln;
    } out_t;

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          h_wrap;
    logic          v_wrap;
    axis_flags_t   h_flags;
    axis_flags_t   v_flags;
    out_t          out_d;
    out_t          out_q;

    lcd_axis_counter #(.TOTAL(H_TOTAL), .W(HW)) u_hcnt (
        .clk   (clk),
        .rst   (rst),
        .adv   (1'b1),
        .count (h_cnt),
        .wrap  (h_wrap)
    );

    lcd_axis_counter #(.TOTAL(V_TOTAL), .W(VW)) u_vcnt (
        .clk   (clk),
        .rst   (rst),
        .adv   (h_wrap),
        .count (v_cnt),
        .wrap  (v_wrap)
    );

    lcd_axis_decode #(.BLANK(H_BLANK), .ACTIVE(H_ACTIVE), .SYNC_W(H_SYNC_W), .W(HW)) u_hdec (
        .count (h_cnt),
        .flags (h_flags)
    );

    lcd_axis_decode #(.BLANK(V_BLANK), .ACTIVE(V_ACTIVE), .SYNC_W(V_SYNC_W), .W(VW)) u_vdec (
        .count (v_cnt),
        .flags (v_flags)
    );

    always_comb begin
        out_d.pins.hsync_n = h_flags.sync_n;
        out_d.pins.vsync_n = v_flags.sync_n;
        out_d.pins.de      = h_flags.active && v_flags.active;
        out_d.pins.rgb     = out_d.pins.de ? FILL : '0;
        out_d.px           = h_cnt;
        out_d.ln           = v_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.pins <= PINS_IDLE;
            out_q.px   <= '0;
            out_q.ln   <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign hsync_n = out_q.pins.hsync_n;
    assign vsync_n = out_q.pins.vsync_n;
    assign de      = out_q.pins.de;
    assign rgb     = out_q.pins.rgb;
    assign px      = out_q.px;
    assign ln      = out_q.ln;

endmodule

// File: rtl/rgb_panel_timer_chk.sv
module rgb_panel_timer_chk #(
    parameter int unsigned H_TOTAL  = 1056,
    parameter int unsigned V_TOTAL  = 525,
    parameter int unsigned H_SYNC_W = 1,
    parameter int unsigned V_SYNC_W = 1,
    parameter int unsigned HW       = 11,
    parameter int unsigned VW       = 10
) (
    input logic          clk,
    input logic          rst,
    input logic [HW-1:0] h_cnt,
    input logic [VW-1:0] v_cnt,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          de,
    input logic [23:0]   rgb,
    input logic [HW-1:0] px,
    input logic [VW-1:0] ln
);

    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] H_ONE  = HW'(1);
    localparam logic [VW-1:0] V_ONE  = VW'(1);
    localparam logic [HW-1:0] H_SW   = HW'(H_SYNC_W);
    localparam logic [VW-1:0] V_SW   = VW'(V_SYNC_W);

    assert_hcnt_step_R2: assert property (@(posedge clk) disable iff (rst)
        (h_cnt != H_LAST) |=> (h_cnt == $past(h_cnt) + H_ONE));

    assert_hcnt_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (h_cnt == H_LAST) |=> (h_cnt == '0));

    assert_vcnt_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (h_cnt != H_LAST) |=> $stable(v_cnt));

    assert_vcnt_step_R3: assert property (@(posedge clk) disable iff (rst)
        (h_cnt == H_LAST && v_cnt != V_LAST) |=> (v_cnt == $past(v_cnt) + V_ONE));

    assert_vcnt_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (h_cnt == H_LAST && v_cnt == V_LAST) |=> (v_cnt == '0));

    assert_hsync_width_R4: assert property (@(posedge clk) disable iff (rst)
        !hsync_n |-> (px < H_SW));

    assert_vsync_width_R5: assert property (@(posedge clk) disable iff (rst)
        !vsync_n |-> (ln < V_SW));

    assert_de_clear_of_sync_R8: assert property (@(posedge clk) disable iff (rst)
        de |-> (hsync_n && vsync_n));

    assert_rgb_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !de |-> (rgb == '0));

    assert_out_align_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (px == $past(h_cnt) && ln == $past(v_cnt)));

endmodule

bind rgb_panel_timer rgb_panel_timer_chk #(
    .H_TOTAL  (H_TOTAL),
    .V_TOTAL  (V_TOTAL),
    .H_SYNC_W (H_SYNC_W),
    .V_SYNC_W (V_SYNC_W),
    .HW       (HW),
    .VW       (VW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .h_cnt   (h_cnt),
    .v_cnt   (v_cnt),
    .hsync_n (hsync_n),
    .vsync_n (vsync_n),
    .de      (de),
    .rgb     (rgb),
    .px      (px),
    .ln      (ln)
);

// File: tb/tb_rgb_panel_timer.sv
module tb_rgb_panel_timer;

    // Small geometry swept over many whole frames
    localparam int S_HA = 8, S_HB = 4, S_HF = 3, S_VA = 5, S_VB = 3, S_VF = 2;
    localparam int S_HSW = 2, S_VSW = 2;
    localparam logic [23:0] S_FILL = 24'h3C5A96;
    // Default geometry, swept up to the first visible pixels
    localparam int D_HA = 800, D_HB = 46, D_HF = 210, D_VA = 480, D_VB = 23, D_VF = 22;
    localparam int D_HSW = 1, D_VSW = 1;
    localparam logic [23:0] D_FILL = 24'hFF0000;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic s_hs, s_vs, s_de;
    logic [23:0] s_rgb;
    logic [3:0] s_px;
    logic [3:0] s_ln;
    logic d_hs, d_vs, d_de;
    logic [23:0] d_rgb;
    logic [10:0] d_px;
    logic [9:0] d_ln;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    rgb_panel_timer #(
        .H_ACTIVE(S_HA), .H_BLANK(S_HB), .H_FRONT(S_HF),
        .V_ACTIVE(S_VA), .V_BLANK(S_VB), .V_FRONT(S_VF),
        .H_SYNC_W(S_HSW), .V_SYNC_W(S_VSW), .FILL(S_FILL)
    ) dut (
        .clk(clk), .rst(rst), .hsync_n(s_hs), .vsync_n(s_vs), .de(s_de),
        .rgb(s_rgb), .px(s_px), .ln(s_ln)
    );

    rgb_panel_timer dut_def (
        .clk(clk), .rst(rst), .hsync_n(d_hs), .vsync_n(d_vs), .de(d_de),
        .rgb(d_rgb), .px(d_px), .ln(d_ln)
    );

    task automatic cmp(string who, string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at t=%0t", who, tag, act, exp, $time);
        end
    endtask

    task automatic check_idle();
        cmp("small", "R1 hsync_n", int'(s_hs), 1);
        cmp("small", "R1 vsync_n", int'(s_vs), 1);
        cmp("small", "R1 de", int'(s_de), 0);
        cmp("small", "R1 rgb", int'(s_rgb), 0);
        cmp("small", "R1 px", int'(s_px), 0);
        cmp("small", "R1 ln", int'(s_ln), 0);
        cmp("default", "R1 hsync_n", int'(d_hs), 1);
        cmp("default", "R1 vsync_n", int'(d_vs), 1);
        cmp("default", "R1 de", int'(d_de), 0);
        cmp("default", "R1 rgb", int'(d_rgb), 0);
        cmp("default", "R1 px", int'(d_px), 0);
        cmp("default", "R1 ln", int'(d_ln), 0);
    endtask

    // n = rising edges since reset release minus one (R10: one clock of latency)
    task automatic check_geom(string who, int n, int ha, int hb, int hf, int va, int vb, int vf,
                              int hsw, int vsw, logic [23:0] fill,
                              logic hs, logic vs, logic den, logic [23:0] col, int x, int y);
        int ht, vt, h, v, hact, vact, dexp;
        ht   = hb + ha + hf;
        vt   = vb + va + vf;
        h    = n % ht;
        v    = (n / ht) % vt;
        hact = (h >= hb && h < hb + ha) ? 1 : 0;
        vact = (v >= vb && v < vb + va) ? 1 : 0;
        dexp = hact & vact;
        cmp(who, "R2 R10 px", x, h);
        cmp(who, "R3 R10 ln", y, v);
        cmp(who, "R4 hsync_n", int'(hs), (h < hsw) ? 0 : 1);
        cmp(who, "R5 vsync_n", int'(vs), (v < vsw) ? 0 : 1);
        cmp(who, "R6 R7 R8 de", int'(den), dexp);
        cmp(who, "R9 rgb", int'(col), dexp ? int'(fill) : 0);
    endtask

    task automatic run(int cycles, int def_limit);
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            check_geom("small", n, S_HA, S_HB, S_HF, S_VA, S_VB, S_VF, S_HSW, S_VSW, S_FILL,
                       s_hs, s_vs, s_de, s_rgb, int'(s_px), int'(s_ln));
            if (n < def_limit) begin
                check_geom("default", n, D_HA, D_HB, D_HF, D_VA, D_VB, D_VF, D_HSW, D_VSW, D_FILL,
                           d_hs, d_vs, d_de, d_rgb, int'(d_px), int'(d_ln));
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle();                 // R1 at power-up
        rst = 1'b0;
        // Default first visible pixel is at index 23*1056+46 = 24334
        run(25400, 25400);
        // Reset in mid-frame, then the count must restart at (0,0)
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_idle();                 // R1 after mid-run reset
        rst = 1'b0;
        run(400, 400);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule